// File: doc/BRIEF.md
# Pipelined Byte-Parity Error Checker

This block watches a data channel on which every byte of data travels with a small group of sideband user bits. The lowest bit of each group is a parity bit for that byte. On each cycle where the channel completes a transfer (valid and ready both high), the block checks every byte against its parity bit under the configured rule, odd or even. If any byte fails, it raises a single-cycle error flag. The block only observes the channel. It never changes the data and never holds the channel back.

The check runs in three steps. The first is an optional input capture. The second reduces each byte to a parity result. The third ORs those results down to one flag. Four register stages can be switched on one at a time through a 4-bit mask, so the delay from transfer to flag can be set anywhere from zero to four cycles to meet timing. The default mask enables only the register after the per-byte results, which gives one cycle of delay. The third stage splits the OR into groups of bytes, so that the enabled midway register sits between the group results and the final OR. Setting the parity mode to none switches the checker off completely.

Top module: `byte_parity_checker`

## Requirements
- R1: While the reset input is low, and on every cycle after its release until the first accepted transfer has passed through the pipeline, `err_out` is low.
- R2: Byte b uses data bits [8b+7:8b] and parity bit `in_user[b*USER_PER_BYTE]`. In even mode (PAR_MODE = 2) the byte is in error when the XOR of its eight data bits and its parity bit is 1. In odd mode (PAR_MODE = 1) it is in error when that XOR is 0.
- R3: Bytes are checked only on a cycle where `in_valid` and `in_ready` are both high. A beat with bad parity that is not accepted never raises `err_out`.
- R4: Every accepted beat with at least one byte in error produces exactly one high cycle of `err_out`, and every accepted clean beat produces a low cycle. Back-to-back failing beats therefore give consecutive high cycles.
- R5: The delay from the accepting cycle to the `err_out` cycle equals the number of set bits in STAGE_MASK. A mask of 0 gives a combinational flag in the same cycle.
- R6: The mask bits control these stages. Bit 0 registers the checked data and its accept flag. Bit 1 registers the per-byte results. Bit 2 registers the per-group OR results of GROUP_BYTES bytes each. Bit 3 registers the flag itself. Any combination is legal.
- R7: With PAR_MODE = 0 (none), `err_out` stays low whatever the channel carries.
- R8: User bits above the lowest one in each byte group have no effect on `err_out`.
- R9: The default STAGE_MASK is 4'b0010, which gives a delay of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released internally in step with the clock |
| in_valid | input | 1 | Channel valid |
| in_ready | input | 1 | Channel ready |
| in_data | input | DATA_W | Channel data |
| in_user | input | DATA_W/8*USER_PER_BYTE | Channel user bits; the lowest bit of each byte group is parity |
| err_out | output | 1 | One-cycle parity error flag per failing accepted beat |

## Verification
Two functions can land in the same cycle. The first is a new beat being accepted and checked. The second is the flag for an earlier beat leaving a deep pipeline. A second case is a stalled beat with bad parity sitting right next to an accepted clean one. The bench provokes both with runs of back-to-back failing beats, failing beats held with ready low or valid low, and a long stretch of random valid, ready and corruption patterns. Five instances with different masks and modes share the same stimulus. A behavioural model delays each beat's verdict by that instance's latency and compares every cycle, so a flag that is lost, duplicated or shifted by one cycle is caught.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2
  } par_mode_e;

  function automatic int unsigned stage_count(input logic [3:0] mask);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      if (mask[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/bpc_rst_sync.sv
module bpc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/bpc_opt_reg.sv
module bpc_opt_reg #(
  parameter int W  = 1,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      always_comb begin
        q_nxt = ld ? d : q_r;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= '0;
        end else begin
          q_r <= q_nxt;
        end
      end

      assign q = q_r;
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = clk ^ rst_n ^ ld;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/bpc_byte_check.sv
module bpc_byte_check
  import bpc_pkg::*;
#(
  parameter int        NBYTE = 4,
  parameter int        UPB   = 1,
  parameter par_mode_e MODE  = PAR_EVEN
) (
  input  logic                   fire,
  input  logic [NBYTE*8-1:0]     data,
  input  logic [NBYTE*UPB-1:0]   user,
  output logic [NBYTE-1:0]       err_vec
);

  logic [NBYTE-1:0] raw;

  generate
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      logic xsum;
      assign xsum   = ^{data[b*8 +: 8], user[b*UPB]};
      assign raw[b] = (MODE == PAR_ODD) ? ~xsum : xsum;
      if (UPB > 1) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^user[b*UPB+1 +: UPB-1];
      end
    end
  endgenerate

  always_comb begin
    if (MODE == PAR_NONE) begin
      err_vec = '0;
    end else begin
      err_vec = raw & {NBYTE{fire}};
    end
  end

endmodule

// File: rtl/bpc_group_or.sv
module bpc_group_or #(
  parameter int NBYTE = 4,
  parameter int GRP   = 4,
  parameter bit EN    = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBYTE-1:0] err_vec,
  output logic             any_err
);

  localparam int NGRP = (NBYTE + GRP - 1) / GRP;
  localparam int PADW = NGRP * GRP;

  logic [PADW-1:0] pad;
  logic [NGRP-1:0] grp_d;
  logic [NGRP-1:0] grp_q;

  assign pad = PADW'(err_vec);

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_d[g] = |pad[g*GRP +: GRP];
    end
  endgenerate

  bpc_opt_reg #(.W(NGRP), .EN(EN)) u_mid (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (1'b1),
    .d     (grp_d),
    .q     (grp_q)
  );

  assign any_err = |grp_q;

endmodule

// File: rtl/byte_parity_checker.sv
module byte_parity_checker
  import bpc_pkg::*;
#(
  parameter int        DATA_W        = 32,
  parameter int        USER_PER_BYTE = 1,
  parameter par_mode_e PAR_MODE      = PAR_EVEN,
  parameter logic [3:0] STAGE_MASK   = 4'b0010,
  parameter int        GROUP_BYTES   = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic                                 in_ready,
  input  logic [DATA_W-1:0]                    in_data,
  input  logic [DATA_W/8*USER_PER_BYTE-1:0]    in_user,
  output logic                                 err_out
);

  localparam int NBYTE  = DATA_W / 8;
  localparam int USER_W = NBYTE * USER_PER_BYTE;
  localparam int PAY_W  = DATA_W + USER_W;

  logic              rst_sync_n;
  logic              fire_in;
  logic              fire_s0;
  logic [PAY_W-1:0]  pay_s0;
  logic [NBYTE-1:0]  err_raw;
  logic [NBYTE-1:0]  err_s1;
  logic              any_s2;

  bpc_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign fire_in = in_valid & in_ready;

  // stage 0: capture accept flag every cycle, payload only on accept
  bpc_opt_reg #(.W(1), .EN(STAGE_MASK[0])) u_s0_fire (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ld    (1'b1),
    .d     (fire_in),
    .q     (fire_s0)
  );

  bpc_opt_reg #(.W(PAY_W), .EN(STAGE_MASK[0])) u_s0_pay (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ld    (fire_in),
    .d     ({in_user, in_data}),
    .q     (pay_s0)
  );

  bpc_byte_check #(
    .NBYTE (NBYTE),
    .UPB   (USER_PER_BYTE),
    .MODE  (PAR_MODE)
  ) u_chk (
    .fire    (fire_s0),
    .data    (pay_s0[DATA_W-1:0]),
    .user    (pay_s0[PAY_W-1:DATA_W]),
    .err_vec (err_raw)
  );

  // stage 1: per-byte results
  bpc_opt_reg #(.W(NBYTE), .EN(STAGE_MASK[1])) u_s1 (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ld    (1'b1),
    .d     (err_raw),
    .q     (err_s1)
  );

  // stage 2: grouped reduction with optional midway register
  bpc_group_or #(
    .NBYTE (NBYTE),
    .GRP   (GROUP_BYTES),
    .EN    (STAGE_MASK[2])
  ) u_red (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .err_vec (err_s1),
    .any_err (any_s2)
  );

  // stage 3: registered flag
  bpc_opt_reg #(.W(1), .EN(STAGE_MASK[3])) u_s3 (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ld    (1'b1),
    .d     (any_s2),
    .q     (err_out)
  );

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker
  import bpc_pkg::*;
#(
  parameter int         DATA_W        = 32,
  parameter int         USER_PER_BYTE = 1,
  parameter par_mode_e  PAR_MODE      = PAR_EVEN,
  parameter logic [3:0] STAGE_MASK    = 4'b0010
) (
  input logic                              clk,
  input logic                              arst_n,
  input logic                              rst_q,
  input logic                              in_valid,
  input logic                              in_ready,
  input logic [DATA_W-1:0]                 in_data,
  input logic [DATA_W/8*USER_PER_BYTE-1:0] in_user,
  input logic                              err_out
);

  localparam int NBYTE = DATA_W / 8;
  localparam int LAT   = stage_count(STAGE_MASK);

  logic       fire_now;
  logic       bad_now;
  logic [3:0] fire_h;
  logic [3:0] bad_h;
  logic [4:0] fire_all;
  logic [4:0] bad_all;

  assign fire_now = in_valid & in_ready;

  always_comb begin
    bad_now = 1'b0;
    for (int b = 0; b < NBYTE; b++) begin
      if (PAR_MODE == PAR_EVEN && (^in_data[b*8 +: 8]) != in_user[b*USER_PER_BYTE])
        bad_now = 1'b1;
      if (PAR_MODE == PAR_ODD && (^in_data[b*8 +: 8]) == in_user[b*USER_PER_BYTE])
        bad_now = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fire_h <= '0;
      bad_h  <= '0;
    end else begin
      fire_h <= {fire_h[2:0], fire_now};
      bad_h  <= {bad_h[2:0], bad_now};
    end
  end

  assign fire_all = {fire_h, fire_now};
  assign bad_all  = {bad_h, bad_now};

  // R1
  quiet_at_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_q) |-> !err_out);

  // R7
  off_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (PAR_MODE == PAR_NONE) |-> !err_out);

  // R3
  no_flag_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !fire_all[LAT] |-> !err_out);

  // R4
  bad_beat_flagged_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (PAR_MODE != PAR_NONE && fire_all[LAT] && bad_all[LAT]) |-> err_out);

  // R2
  flag_means_bad_chk: assert property (@(posedge clk) disable iff (!rst_q)
    err_out |-> bad_all[LAT]);

endmodule

bind byte_parity_checker bpc_checker #(
  .DATA_W        (DATA_W),
  .USER_PER_BYTE (USER_PER_BYTE),
  .PAR_MODE      (PAR_MODE),
  .STAGE_MASK    (STAGE_MASK)
) u_bpc_checker (
  .clk      (clk),
  .arst_n   (rst_n),
  .rst_q    (rst_sync_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .in_user  (in_user),
  .err_out  (err_out)
);

// File: tb/byte_parity_checker_test.sv
module byte_parity_checker_test;
  import bpc_pkg::*;

  localparam int DW    = 32;
  localparam int UPB   = 2;
  localparam int NB    = DW / 8;
  localparam int DEPTH = 4096;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic [NB*UPB-1:0] in_user;

  logic err_uut, err_comb, err_full, err_mid, err_off;

  int checks;
  int failures;
  int cyc;
  bit done;
  string cur_tag;

  bit    ev_e [DEPTH];
  bit    ev_o [DEPTH];
  string tg   [DEPTH];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // default mask 0010, even mode (R9)
  byte_parity_checker #(.DATA_W(DW), .USER_PER_BYTE(UPB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_user(in_user), .err_out(err_uut));

  byte_parity_checker #(.DATA_W(DW), .USER_PER_BYTE(UPB), .PAR_MODE(PAR_EVEN),
    .STAGE_MASK(4'b0000)) u_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_user(in_user), .err_out(err_comb));

  byte_parity_checker #(.DATA_W(DW), .USER_PER_BYTE(UPB), .PAR_MODE(PAR_ODD),
    .STAGE_MASK(4'b1111), .GROUP_BYTES(2)) u_full (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_user(in_user), .err_out(err_full));

  byte_parity_checker #(.DATA_W(DW), .USER_PER_BYTE(UPB), .PAR_MODE(PAR_ODD),
    .STAGE_MASK(4'b0100), .GROUP_BYTES(2)) u_mid (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_user(in_user), .err_out(err_mid));

  byte_parity_checker #(.DATA_W(DW), .USER_PER_BYTE(UPB), .PAR_MODE(PAR_NONE),
    .STAGE_MASK(4'b0101)) u_off (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_user(in_user), .err_out(err_off));

  function automatic bit delayed(input bit is_even, input int lat);
    if (cyc < lat) return 1'b0;
    return is_even ? ev_e[cyc-lat] : ev_o[cyc-lat];
  endfunction

  function automatic string delayed_tag(input int lat);
    if (cyc < lat) return "R1";
    return tg[cyc-lat];
  endfunction

  task automatic check1(input string inst, input string itag, input int lat,
                        input logic act, input bit exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s %s beat=%s cycle=%0d actual=%b expected=%b",
               inst, itag, delayed_tag(lat), cyc, act, exp_v);
    end
  endtask

  // reference model: each cycle, record the verdict per mode and compare
  // every instance against the verdict delayed by its own latency
  always begin
    bit fire, bad_e, bad_o;
    @(negedge clk);
    #3;
    fire  = in_valid && in_ready && rst_n;
    bad_e = 1'b0;
    bad_o = 1'b0;
    for (int b = 0; b < NB; b++) begin
      // R2: even fails on XOR 1, odd fails on XOR 0; parity at user[b*UPB]
      if ((^in_data[b*8 +: 8]) ^ in_user[b*UPB]) bad_e = 1'b1;
      else                                         bad_o = 1'b1;
    end
    if (cyc < DEPTH) begin
      ev_e[cyc] = fire && bad_e;
      ev_o[cyc] = fire && bad_o;
      tg[cyc]   = cur_tag;
      check1("uut",    "R9", 1, err_uut,  delayed(1'b1, 1));
      check1("u_comb", "R5", 0, err_comb, delayed(1'b1, 0));
      check1("u_full", "R6", 4, err_full, delayed(1'b0, 4));
      check1("u_mid",  "R6", 1, err_mid,  delayed(1'b0, 1));
      check1("u_off",  "R7", 2, err_off,  1'b0);
      cyc++;
    end
  end

  // drive one cycle; badm marks bytes whose parity bit is wrong for even
  task automatic drive(input bit v, input bit r, input logic [NB-1:0] badm,
                       input bit rand_hi, input string tag);
    logic [DW-1:0] d;
    @(negedge clk);
    d = $urandom;
    in_data  = d;
    in_valid = v;
    in_ready = r;
    for (int b = 0; b < NB; b++) begin
      in_user[b*UPB]     = (^d[b*8 +: 8]) ^ badm[b];
      in_user[b*UPB + 1] = rand_hi ? 1'($urandom) : 1'b0;
    end
    cur_tag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    cyc      = 0;
    done     = 1'b0;
    cur_tag  = "R1";
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_ready = 1'b0;
    in_data  = '0;
    in_user  = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(6, "R1");

    // R2: clean beats (even passes, odd fails on every byte)
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, '0, 1'b0, "R2");
    idle(5, "R2");
    // R2: one corrupted byte in each position, then all bytes
    for (int b = 0; b < NB; b++) begin
      drive(1'b1, 1'b1, 4'(1 << b), 1'b0, "R2");
      idle(2, "R2");
    end
    drive(1'b1, 1'b1, '1, 1'b0, "R2");
    idle(5, "R2");

    // R3: corrupted beat offered but not accepted
    drive(1'b1, 1'b0, 4'b0101, 1'b0, "R3");
    drive(1'b0, 1'b1, 4'b1010, 1'b0, "R3");
    drive(1'b1, 1'b1, '0, 1'b0, "R3");
    drive(1'b1, 1'b0, '1, 1'b0, "R3");
    idle(5, "R3");

    // R4: back-to-back failing beats, then alternating
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b1, 4'b0010, 1'b0, "R4");
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, (i % 2) ? 4'b0000 : 4'b1000, 1'b0, "R4");
    idle(5, "R4");

    // R8: upper user bits toggle freely
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, '0, 1'b1, "R8");
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b1, 4'b0001, 1'b1, "R8");
    idle(5, "R8");

    // R4 R5: random traffic
    for (int i = 0; i < 400; i++) begin
      logic [NB-1:0] m;
      m = ($urandom % 2 == 0) ? '0 : 4'($urandom);
      drive(($urandom % 4) != 0, ($urandom % 3) != 0, m, 1'b1, "R4");
    end
    idle(8, "R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule